// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block is the receiving end of a write-only three-wire control port made of a serial clock, a serial data line and a latch strobe. All three pins are sampled by the system clock. Bits are collected into a 24-bit word, first bit at the top. A rising edge on the latch strobe hands the word to an address decoder. The decoder looks at the low end of the word and stores the whole word in one of seven control registers. A one-cycle update pulse marks which register changed.

Register 0 holds the RF divider settings and a mode bit at its top position. While the mode bit is set, the three IF divider outputs come from fixed parameter values. While it is clear, they come from fields programmed in registers 4 and 5. A host normally sends registers 6 down to 0 once, and afterwards retunes by rewriting register 0 alone. Each serial pin level must be held for at least three system clock cycles.

Top module: `tws_loader`

## Requirements
- R1: On each rising edge of `ser_clk`, the level of `ser_dat` is shifted in at bit 0 and earlier bits move toward bit 23, so the first bit sent of a 24-bit frame ends up at bit 23 of the stored word.
- R2: A control register is written only after a low-to-high transition of `ser_le`. Shifting bits while `ser_le` stays high, or stays low, leaves every register and every update pulse unchanged.
- R3: A latch edge that follows fewer than 24 shifted bits since reset or since the previous latch edge is discarded: no register changes and no pulse appears. When more than 24 bits were shifted, the last 24 are used.
- R4: The destination is decoded from the low bits of the word: `..00` is register 0, `..01` is register 1, `..0011` is register 2, `..1011` is register 3, `..0111` is register 4, `..01111` is register 5 and `..11111` is register 6. The whole 24-bit word is stored, including its address bits.
- R5: Every accepted frame raises `upd_stb[i]` for exactly one system clock cycle, where i is the destination register. At most one bit of `upd_stb` is high at a time.
- R6: Synchronous reset loads register 0 with 0x800000 and registers 1 to 6 with their bare address codes (0x000001, 0x000003, 0x00000B, 0x000007, 0x00000F, 0x00001F). It also clears `upd_stb`.
- R7: The fields of register 0 are output directly: `def_sel` is bit 23, `rf_b` is bits 19:16, `rf_a` is bits 15:13 and `rf_fn` is bits 12:2.
- R8: While `def_sel` is 1, `if_a`, `if_b` and `if_r` equal the parameters DEF_IF_A (5), DEF_IF_B (100) and DEF_IF_R (20). While `def_sel` is 0, `if_a` is register 4 bits 17:14, `if_b` is register 4 bits 13:5 and `if_r` is register 5 bits 13:5.
- R9: When a rising `ser_clk` edge and a rising `ser_le` edge reach the block in the same system cycle, the bit is shifted in first, and the decoded word includes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch strobe, asynchronous |
| ctrl_words | output | 168 | Register i at bits [24*i+23 : 24*i] |
| upd_stb | output | 7 | One-cycle update pulse per register |
| def_sel | output | 1 | Register 0 bit 23, IF default select |
| rf_b | output | 4 | RF B counter, register 0 bits 19:16 |
| rf_a | output | 3 | RF A counter, register 0 bits 15:13 |
| rf_fn | output | 11 | RF fractional numerator, register 0 bits 12:2 |
| if_a | output | 4 | Effective IF A counter |
| if_b | output | 9 | Effective IF B counter |
| if_r | output | 9 | Effective IF R counter |

## Verification
The 24th serial clock edge and the latch edge can be seen in the same system cycle. The bench provokes this by raising `ser_clk` and `ser_le` at the same instant, after 23 bits have been sent. The result is correct only if the stored word carries that last bit at position 0 and a single update pulse follows for the register its address names. Random frames, short frames, long frames and frames shifted while the latch strobe is held high fill in the other orderings.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int WORD_W   = 24;
    localparam int NUM_REGS = 7;
    localparam int CNT_W    = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        SEL_R0 = 3'd0,
        SEL_R1 = 3'd1,
        SEL_R2 = 3'd2,
        SEL_R3 = 3'd3,
        SEL_R4 = 3'd4,
        SEL_R5 = 3'd5,
        SEL_R6 = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    typedef struct packed {
        logic        def_sel;
        logic [3:0]  b_cnt;
        logic [2:0]  a_cnt;
        logic [10:0] frac_num;
    } rf_fields_t;

    typedef struct packed {
        logic [3:0] a_cnt;
        logic [8:0] b_cnt;
        logic [8:0] r_cnt;
    } if_fields_t;

    // Address codes have different lengths; the code set is prefix-free.
    function automatic decode_t decode_addr(input word_t w);
        decode_t d;
        d.hit = 1'b1;
        d.sel = SEL_R0;
        if (w[1:0] == 2'b00)        d.sel = SEL_R0;
        else if (w[1:0] == 2'b01)   d.sel = SEL_R1;
        else if (w[3:0] == 4'b0011) d.sel = SEL_R2;
        else if (w[3:0] == 4'b1011) d.sel = SEL_R3;
        else if (w[3:0] == 4'b0111) d.sel = SEL_R4;
        else if (w[4:0] == 5'b01111) d.sel = SEL_R5;
        else if (w[4:0] == 5'b11111) d.sel = SEL_R6;
        else d.hit = 1'b0;
        return d;
    endfunction

    function automatic word_t reset_word(input int idx);
        case (idx)
            0:       return 24'h800000;
            1:       return 24'h000001;
            2:       return 24'h000003;
            3:       return 24'h00000B;
            4:       return 24'h000007;
            5:       return 24'h00000F;
            default: return 24'h00001F;
        endcase
    endfunction

    function automatic rf_fields_t unpack_rf(input word_t w);
        rf_fields_t f;
        f.def_sel  = w[23];
        f.b_cnt    = w[19:16];
        f.a_cnt    = w[15:13];
        f.frac_num = w[12:2];
        return f;
    endfunction

    function automatic if_fields_t unpack_if(input word_t w4, input word_t w5);
        if_fields_t f;
        f.a_cnt = w4[17:14];
        f.b_cnt = w4[13:5];
        f.r_cnt = w5[13:5];
        return f;
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [N-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe_q[0] <= '0;
        else     pipe_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe_q[s] <= '0;
            else     pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter import tws_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  sh_en,
    input  logic  sh_bit,
    input  logic  latch,
    output logic  frame_vld,
    output word_t frame_word
);

    word_t            sr_q, sr_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;

    always_comb begin
        sr_nxt  = sr_q;
        cnt_nxt = cnt_q;
        if (sh_en) begin
            sr_nxt = {sr_q[WORD_W-2:0], sh_bit};
            if (cnt_q != CNT_W'(WORD_W)) cnt_nxt = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            cnt_q      <= '0;
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            sr_q      <= sr_nxt;
            cnt_q     <= latch ? '0 : cnt_nxt;
            frame_vld <= latch && (cnt_nxt == CNT_W'(WORD_W));
            if (latch) frame_word <= sr_nxt;
        end
    end

    // R1: new bit enters at bit 0, older bits move up
    a_r1_msb_first: assert property (@(posedge clk) disable iff (rst)
        sh_en |=> (sr_q[0] == $past(sh_bit)) &&
                  (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])));

    // R2: a frame is only produced after a latch edge
    a_r2_vld_after_latch: assert property (@(posedge clk) disable iff (rst)
        frame_vld |-> $past(latch));

    // R3: short frames are dropped
    a_r3_short_dropped: assert property (@(posedge clk) disable iff (rst)
        (latch && (cnt_q < CNT_W'(WORD_W - 1))) |=> !frame_vld);

    // R9: coincident last bit and latch edge produce a frame including the bit
    a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (sh_en && latch && (cnt_q == CNT_W'(WORD_W - 1)))
            |=> frame_vld && (frame_word[0] == $past(sh_bit)));

endmodule

// File: rtl/tws_regfile.sv
module tws_regfile import tws_pkg::*; (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_vld,
    input  word_t                    frame_word,
    output word_t [NUM_REGS-1:0]     regs_o,
    output logic  [NUM_REGS-1:0]     upd_o
);

    decode_t dec;

    always_comb dec = decode_addr(frame_word);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit_here;
        assign hit_here = frame_vld && dec.hit && (dec.sel == reg_sel_e'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_o[i] <= reset_word(i);
                upd_o[i]  <= 1'b0;
            end else begin
                upd_o[i] <= hit_here;
                if (hit_here) regs_o[i] <= frame_word;
            end
        end

        // R2: register only moves together with its update pulse
        a_r2_hold_without_update: assert property (@(posedge clk) disable iff (rst)
            !upd_o[i] |-> $stable(regs_o[i]));

        // R4: the stored word carries the address of its own register
        a_r4_addr_matches: assert property (@(posedge clk) disable iff (rst)
            upd_o[i] |-> (decode_addr(regs_o[i]).sel == reg_sel_e'(i)));

        // R5: update pulse lasts a single cycle
        a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
            upd_o[i] |=> !upd_o[i]);
    end

    // R5: never more than one register updated per cycle
    a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o));

endmodule

// File: rtl/tws_loader.sv
module tws_loader import tws_pkg::*; #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEF_IF_A    = 4'd5,
    parameter logic [8:0] DEF_IF_B    = 9'd100,
    parameter logic [8:0] DEF_IF_R    = 9'd20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ser_clk,
    input  logic                         ser_dat,
    input  logic                         ser_le,
    output logic [NUM_REGS*WORD_W-1:0]   ctrl_words,
    output logic [NUM_REGS-1:0]          upd_stb,
    output logic                         def_sel,
    output logic [3:0]                   rf_b,
    output logic [2:0]                   rf_a,
    output logic [10:0]                  rf_fn,
    output logic [3:0]                   if_a,
    output logic [8:0]                   if_b,
    output logic [8:0]                   if_r
);

    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_LE  = 2;

    logic [2:0]           pins_sync;
    logic                 clk_prev_q, le_prev_q;
    logic                 sh_en, latch;
    logic                 frame_vld;
    word_t                frame_word;
    word_t [NUM_REGS-1:0] regs;
    rf_fields_t           rf_f;
    if_fields_t           if_prog;

    tws_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_le, ser_dat, ser_clk}),
        .sync_out (pins_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev_q <= 1'b0;
            le_prev_q  <= 1'b0;
        end else begin
            clk_prev_q <= pins_sync[PIN_CLK];
            le_prev_q  <= pins_sync[PIN_LE];
        end
    end

    assign sh_en = pins_sync[PIN_CLK] && !clk_prev_q;
    assign latch = pins_sync[PIN_LE]  && !le_prev_q;

    tws_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sh_en      (sh_en),
        .sh_bit     (pins_sync[PIN_DAT]),
        .latch      (latch),
        .frame_vld  (frame_vld),
        .frame_word (frame_word)
    );

    tws_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .frame_vld  (frame_vld),
        .frame_word (frame_word),
        .regs_o     (regs),
        .upd_o      (upd_stb)
    );

    assign ctrl_words = regs;

    always_comb begin
        rf_f    = unpack_rf(regs[0]);
        if_prog = unpack_if(regs[4], regs[5]);
    end

    assign def_sel = rf_f.def_sel;
    assign rf_b    = rf_f.b_cnt;
    assign rf_a    = rf_f.a_cnt;
    assign rf_fn   = rf_f.frac_num;

    always_comb begin
        if (def_sel) begin
            if_a = DEF_IF_A;
            if_b = DEF_IF_B;
            if_r = DEF_IF_R;
        end else begin
            if_a = if_prog.a_cnt;
            if_b = if_prog.b_cnt;
            if_r = if_prog.r_cnt;
        end
    end

    // R8: default mode pins the IF outputs to the built-in values
    a_r8_default_values: assert property (@(posedge clk) disable iff (rst)
        def_sel |-> (if_a == DEF_IF_A) && (if_b == DEF_IF_B) && (if_r == DEF_IF_R));

    // R8: in programmed mode IF outputs only move when register 4 or 5 or 0 is written
    a_r8_prog_stable: assert property (@(posedge clk) disable iff (rst)
        (!def_sel && $past(!def_sel) && !upd_stb[4] && !upd_stb[5] && !upd_stb[0])
            |-> $stable(if_a) && $stable(if_b) && $stable(if_r));

    // R7: RF fields only change alongside a register 0 update
    a_r7_rf_stable: assert property (@(posedge clk) disable iff (rst)
        !upd_stb[0] |-> $stable(rf_b) && $stable(rf_a) && $stable(rf_fn) && $stable(def_sel));

endmodule

// File: tb/tws_loader_bench.sv
module tws_loader_bench;
    import tws_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_le = 1'b0;
    logic [167:0] ctrl_words;
    logic [6:0]  upd_stb;
    logic        def_sel;
    logic [3:0]  rf_b;
    logic [2:0]  rf_a;
    logic [10:0] rf_fn;
    logic [3:0]  if_a;
    logic [8:0]  if_b;
    logic [8:0]  if_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] exp_words [7];
    int          exp_cnt [7];
    int          stb_cnt [7];
    int          wide_pulses = 0;
    logic [6:0]  prev_stb = '0;

    always #10 clk = ~clk;

    tws_loader u_tws_loader (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ctrl_words(ctrl_words), .upd_stb(upd_stb), .def_sel(def_sel),
        .rf_b(rf_b), .rf_a(rf_a), .rf_fn(rf_fn), .if_a(if_a), .if_b(if_b), .if_r(if_r)
    );

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 7; i++) if (upd_stb[i]) stb_cnt[i]++;
            if ((upd_stb & prev_stb) != 0) wide_pulses++;
            if ($countones(upd_stb) > 1) wide_pulses++;
            prev_stb = upd_stb;
        end
    end

    function automatic int dest_of(input logic [23:0] w);
        if (w[4:0] == 5'b11111) return 6;
        if (w[4:0] == 5'b01111) return 5;
        if (w[3:0] == 4'b0111)  return 4;
        if (w[3:0] == 4'b1011)  return 3;
        if (w[3:0] == 4'b0011)  return 2;
        if (w[1:0] == 2'b01)    return 1;
        return 0;
    endfunction

    function automatic logic [23:0] with_addr(input logic [23:0] w, input int d);
        logic [23:0] r = w;
        case (d)
            0: r[1:0] = 2'b00;
            1: r[1:0] = 2'b01;
            2: r[3:0] = 4'b0011;
            3: r[3:0] = 4'b1011;
            4: r[3:0] = 4'b0111;
            5: r[4:0] = 5'b01111;
            default: r[4:0] = 5'b11111;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] exp_if_a();
        return exp_words[0][23] ? 4'd5 : exp_words[4][17:14];
    endfunction
    function automatic logic [8:0] exp_if_b();
        return exp_words[0][23] ? 9'd100 : exp_words[4][13:5];
    endfunction
    function automatic logic [8:0] exp_if_r();
        return exp_words[0][23] ? 9'd20 : exp_words[5][13:5];
    endfunction

    task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        for (int i = 0; i < 7; i++) begin
            check_eq({tag, " R1 R4 word"}, 64'(ctrl_words[i*24 +: 24]), 64'(exp_words[i]));
            check_eq({tag, " R5 pulse count"}, 64'(stb_cnt[i]), 64'(exp_cnt[i]));
        end
        check_eq({tag, " R7 def_sel"}, 64'(def_sel), 64'(exp_words[0][23]));
        check_eq({tag, " R7 rf_b"},  64'(rf_b),  64'(exp_words[0][19:16]));
        check_eq({tag, " R7 rf_a"},  64'(rf_a),  64'(exp_words[0][15:13]));
        check_eq({tag, " R7 rf_fn"}, 64'(rf_fn), 64'(exp_words[0][12:2]));
        check_eq({tag, " R8 if_a"},  64'(if_a),  64'(exp_if_a()));
        check_eq({tag, " R8 if_b"},  64'(if_b),  64'(exp_if_b()));
        check_eq({tag, " R8 if_r"},  64'(if_r),  64'(exp_if_r()));
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic pulse_le();
        repeat (2) @(negedge clk);
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic accept(input logic [23:0] w);
        int d = dest_of(w);
        exp_words[d] = w;
        exp_cnt[d]++;
    endtask

    task automatic send_frame(input logic [23:0] w);
        shift_bits(64'(w), 24);
        pulse_le();
        accept(w);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        int          d;
        int          seed_val;
        seed_val = int'($urandom(32'd4177));
        for (int i = 0; i < 7; i++) begin
            stb_cnt[i] = 0;
            exp_cnt[i] = 0;
        end
        exp_words[0] = 24'h800000; exp_words[1] = 24'h000001;
        exp_words[2] = 24'h000003; exp_words[3] = 24'h00000B;
        exp_words[4] = 24'h000007; exp_words[5] = 24'h00000F;
        exp_words[6] = 24'h00001F;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R6: reset state
        check_eq("R6 upd_stb at reset", 64'(upd_stb), 64'd0);
        check_all("R6 reset");

        // Directed: program IF fields, then leave default mode (R8, R4)
        send_frame(with_addr({6'd0, 4'd9, 9'd300, 5'd0}, 4));
        send_frame(with_addr({10'd0, 9'd411, 5'd0}, 5));
        check_all("R8 default still on");
        send_frame(with_addr({1'b0, 3'b101, 4'd11, 3'd6, 11'd1234, 2'b00}, 0));
        check_all("R7 R8 programmed");
        send_frame(24'hA5A5_0B);
        send_frame(24'h3C3C_03);
        send_frame(24'hFFFF_FF);
        send_frame(24'h1234_5D);
        check_all("R4 all addresses");

        // R3: short frame dropped
        shift_bits(64'h3FF, 10);
        pulse_le();
        check_all("R3 short frame");

        // R3: long frame keeps the last 24 bits
        w = with_addr(24'h6B_1E_40, 1);
        shift_bits(64'h2A, 6);
        send_frame(w);
        check_all("R3 long frame");

        // R2: bits shifted while latch held high do not update
        w = with_addr(24'h55_AA_00, 6);
        repeat (2) @(negedge clk);
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        shift_bits(64'(w), 24);
        repeat (8) @(negedge clk);
        check_all("R2 latch held high");
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        check_all("R2 latch falling");
        pulse_le();
        accept(w);
        check_all("R2 after rising edge");

        // R9: last serial edge and latch edge in the same instant
        w = with_addr(24'hC3_96_71, 2);
        shift_bits(64'(w[23:1]), 23);
        ser_dat = w[0];
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        ser_le  = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        ser_le  = 1'b0;
        repeat (8) @(negedge clk);
        accept(w);
        check_all("R9 coincident edges");

        // Random frames (R1, R4, R5, R8)
        for (int n = 0; n < 40; n++) begin
            w = 24'($urandom);
            d = int'($urandom_range(0, 6));
            send_frame(with_addr(w, d));
            if (n % 8 == 7) check_all("R1 random");
        end
        check_all("R1 random end");

        check_eq("R5 pulse width and exclusivity", 64'(wide_pulses), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule